// File: doc/BRIEF.md
# Accumulator Fetch-Execute Sequencer

This block is the control and datapath core of a small single-accumulator processor. It keeps a program counter, a memory address register, a memory data register, an instruction register and the accumulator. Every instruction runs as a fixed series of one-clock states. Every memory transfer passes through the address and data registers. The block is connected to one external synchronous memory. It presents an address, write data, a read strobe and a write strobe, and it accepts read data and a ready input.

A memory state that sees ready low repeats itself with the same address and strobe, and it only moves on in the cycle where ready is high. Instruction words are 16 bits wide. The upper four bits give the operation and the lower twelve bits give a memory address. The block runs load, store, add, subtract, jump, branch-on-zero-accumulator and halt. After a halt the block stays idle until it is reset.

Top module: `acc_seq_core`

## Requirements
- R1: A synchronous reset (`rst` high) clears the program counter, accumulator and instruction register, keeps `halted`, `mem_rd` and `mem_wr` low, and makes the first fetch read address 0 in the second clock after reset is released.
- R2: A fetch takes three states in this order: program counter into the address register, then a read (`mem_rd` high, `mem_addr` equal to the program counter) into the data register, then data register into the instruction register.
- R3: An instruction word carries its opcode in bits 15:12 and its address operand in bits 11:0. The opcodes are 1 load, 2 store, 3 add, 4 subtract, 5 jump, 6 branch-if-zero and 7 halt. Every other opcode acts as a no-op that only advances the program counter.
- R4: A load reads the operand address and places the returned word in the accumulator.
- R5: A store drives the accumulator value on `mem_wdata` at the operand address with `mem_wr` high, and the write completes in exactly one cycle in which `mem_ready` is high.
- R6: An add or subtract reads the operand and writes accumulator plus or minus that word back to the accumulator, modulo 2^16.
- R7: The program counter advances by one in each instruction's fetch, so without a jump the next fetch reads the following address.
- R8: A jump loads the program counter from the address field, and the next fetch reads that address.
- R9: A branch-if-zero loads the program counter from the address field only when the accumulator is zero. Otherwise execution continues at the next address.
- R10: A halt raises `halted`. The output stays high, and neither strobe is asserted again, until reset.
- R11: Each state takes one clock when `mem_ready` is high. A memory state in which `mem_ready` is low repeats with an unchanged address, strobe and write data.
- R12: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Memory address (address register) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data (data register) |
| mem_rdata | input | 16 | Read data, valid while ready is high |
| mem_ready | input | 1 | Memory completes the current access |
| halted | output | 1 | High while stopped by a halt |

## Verification
A wait state can fall on the same cycle as the completion of a store or of an operand read. A write held for several cycles must be committed exactly once, and a read held for several cycles must capture only the word present when ready rises. The bench provokes this by replaying the same program with a pseudo-random ready pattern. It judges the run with scoreboards that pop one expected address per ready-qualified read and one expected address/data pair per ready-qualified write. Beside the scoreboards, a port-level monitor confirms that every stalled cycle is followed by the same strobe and address. The stall-free run is also timed to an exact cycle count.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 4'h0,
    OP_LOAD  = 4'h1,
    OP_STORE = 4'h2,
    OP_ADD   = 4'h3,
    OP_SUB   = 4'h4,
    OP_JMP   = 4'h5,
    OP_BZ    = 4'h6,
    OP_HALT  = 4'h7
  } opcode_t;

  typedef enum logic [2:0] {
    ST_FADDR,
    ST_FREAD,
    ST_FIR,
    ST_DEC,
    ST_XREAD,
    ST_XWB,
    ST_XWRITE,
    ST_HALT
  } state_t;

  // register-transfer enables issued by the sequencer
  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic mdr_from_mem;
    logic mdr_from_acc;
    logic ir_from_mdr;
    logic pc_inc;
    logic pc_from_ir;
    logic acc_from_alu;
  } ctl_t;

endpackage

// File: rtl/acc_seq_alu.sv
module acc_seq_alu
  import acc_seq_pkg::*;
#(
  parameter int DW = 16
) (
  input  opcode_t       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);

  function automatic logic [DW-1:0] alu_eval(opcode_t f, logic [DW-1:0] x, logic [DW-1:0] m);
    case (f)
      OP_LOAD: return m;
      OP_ADD:  return x + m;
      OP_SUB:  return x - m;
      default: return x;
    endcase
  endfunction

  assign y = alu_eval(op, a, b);

endmodule

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
  import acc_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  opcode_t opcode,
  input  logic    acc_zero,
  input  logic    mem_ready,
  output ctl_t    ctl,
  output logic    mem_rd,
  output logic    mem_wr,
  output logic    halted
);

  state_t state_q, state_d;

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_FADDR;
    else     state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    ctl     = '0;
    mem_rd  = 1'b0;
    mem_wr  = 1'b0;
    case (state_q)
      ST_FADDR: begin
        ctl.mar_from_pc = 1'b1;
        state_d = ST_FREAD;
      end
      ST_FREAD: begin
        mem_rd = 1'b1;
        if (mem_ready) begin
          ctl.mdr_from_mem = 1'b1;
          state_d = ST_FIR;
        end
      end
      ST_FIR: begin
        ctl.ir_from_mdr = 1'b1;
        ctl.pc_inc      = 1'b1;
        state_d = ST_DEC;
      end
      ST_DEC: begin
        state_d = ST_FADDR;
        case (opcode)
          OP_LOAD, OP_ADD, OP_SUB: begin
            ctl.mar_from_ir = 1'b1;
            state_d = ST_XREAD;
          end
          OP_STORE: begin
            ctl.mar_from_ir  = 1'b1;
            ctl.mdr_from_acc = 1'b1;
            state_d = ST_XWRITE;
          end
          OP_JMP:  ctl.pc_from_ir = 1'b1;
          OP_BZ:   ctl.pc_from_ir = acc_zero;
          OP_HALT: state_d = ST_HALT;
          default: state_d = ST_FADDR;
        endcase
      end
      ST_XREAD: begin
        mem_rd = 1'b1;
        if (mem_ready) begin
          ctl.mdr_from_mem = 1'b1;
          state_d = ST_XWB;
        end
      end
      ST_XWB: begin
        ctl.acc_from_alu = 1'b1;
        state_d = ST_FADDR;
      end
      ST_XWRITE: begin
        mem_wr = 1'b1;
        if (mem_ready) state_d = ST_FADDR;
      end
      default: state_d = ST_HALT;
    endcase
  end

  assign halted = (state_q == ST_HALT);

  // named events for the checks
  wire mem_stall  = (mem_rd || mem_wr) && !mem_ready;
  wire wr_commit  = mem_wr && mem_ready;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!halted && !mem_rd && !mem_wr));

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_stall |=> ($stable(mem_rd) && $stable(mem_wr)));

  // R5
  write_once_chk: assert property (@(posedge clk) disable iff (rst)
    wr_commit |=> !mem_wr);

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !mem_rd && !mem_wr));

endmodule

// File: rtl/acc_seq_dpath.sv
module acc_seq_dpath
  import acc_seq_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  ctl_t          ctl,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] alu_y,
  output logic [AW-1:0] mar,
  output logic [DW-1:0] mdr,
  output logic [DW-1:0] acc,
  output opcode_t       opcode,
  output logic          acc_zero
);

  logic [AW-1:0] pc_q;
  logic [DW-1:0] ir_q;

  wire [AW-1:0] ir_addr = ir_q[AW-1:0];
  wire [AW-1:0] pc_next = pc_q + {{(AW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      ir_q <= '0;
      acc  <= '0;
      mar  <= '0;
      mdr  <= '0;
    end else begin
      if (ctl.mar_from_pc)       mar <= pc_q;
      else if (ctl.mar_from_ir)  mar <= ir_addr;
      if (ctl.mdr_from_mem)      mdr <= mem_rdata;
      else if (ctl.mdr_from_acc) mdr <= acc;
      if (ctl.ir_from_mdr)       ir_q <= mdr;
      if (ctl.pc_from_ir)        pc_q <= ir_addr;
      else if (ctl.pc_inc)       pc_q <= pc_next;
      if (ctl.acc_from_alu)      acc <= alu_y;
    end
  end

  assign opcode   = opcode_t'(ir_q[DW-1 -: OP_W]);
  assign acc_zero = (acc == '0);

  wire pc_step  = ctl.pc_inc && !ctl.pc_from_ir;
  wire pc_redir = ctl.pc_from_ir;

  // R7
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    pc_step |=> (pc_q == $past(pc_q) + AW'(1)));

  // R8
  pc_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    pc_redir |=> (pc_q == $past(ir_q[AW-1:0])));

endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
  import acc_seq_pkg::*;
#(
  parameter int AW = 12,
  localparam int DW = OP_W + AW
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          halted
);

  ctl_t          ctl;
  opcode_t       opcode;
  logic          acc_zero;
  logic [DW-1:0] acc, mdr, alu_y;
  logic [AW-1:0] mar;

  acc_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .opcode(opcode), .acc_zero(acc_zero),
    .mem_ready(mem_ready), .ctl(ctl), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .halted(halted)
  );

  acc_seq_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk(clk), .rst(rst), .ctl(ctl), .mem_rdata(mem_rdata), .alu_y(alu_y),
    .mar(mar), .mdr(mdr), .acc(acc), .opcode(opcode), .acc_zero(acc_zero)
  );

  acc_seq_alu #(.DW(DW)) u_alu (
    .op(opcode), .a(acc), .b(mdr), .y(alu_y)
  );

  assign mem_addr  = mar;
  assign mem_wdata = mdr;

  // R11
  wdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && !mem_ready) |=> $stable(mem_wdata) && $stable(mem_addr));

endmodule

// File: tb/acc_seq_core_bench.sv
module acc_seq_core_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_wr, halted;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_ready;

  always #10 clk = ~clk;   // 50 MHz

  acc_seq_core u_acc_seq_core (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .halted(halted)
  );

  // ---------------- memory model ----------------
  logic [15:0] bmem [0:255];
  logic        ld_en = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic        ready_rand = 1'b0;
  logic [7:0]  lfsr = 8'hA5;

  always @(posedge clk) begin
    if (ld_en) bmem[ld_addr] <= ld_data;
    else if (mem_wr && mem_ready) bmem[mem_addr[7:0]] <= mem_wdata;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end
  assign mem_rdata = bmem[mem_addr[7:0]];
  assign mem_ready = ready_rand ? lfsr[0] : 1'b1;

  // ---------------- bookkeeping ----------------
  int n_tests = 0;
  int n_fail  = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct packed { logic [11:0] a; logic [15:0] d; } wr_item_t;
  logic [11:0] rd_q [$];
  wr_item_t    wr_q [$];

  task automatic expect_read(input logic [11:0] a);
    rd_q.push_back(a);
  endtask
  task automatic expect_write(input logic [11:0] a, input logic [15:0] d);
    wr_q.push_back({a, d});
  endtask

  // ---------------- monitor ----------------
  logic        prev_stall = 1'b0;
  logic        prev_rd = 1'b0, prev_wr = 1'b0;
  logic [11:0] prev_addr = '0;
  logic [15:0] prev_wdata = '0;

  always @(negedge clk) begin
    if (rst) begin
      prev_stall <= 1'b0;
    end else begin
      if (prev_stall)  // R11 hold on stall
        check(mem_rd == prev_rd && mem_wr == prev_wr && mem_addr == prev_addr &&
              (!mem_wr || mem_wdata == prev_wdata),
              "R11 stall hold", int'(mem_addr), int'(prev_addr));
      if (mem_rd && mem_wr) check(1'b0, "R12 both strobes", 1, 0);
      if (mem_rd && mem_ready) begin
        if (rd_q.size() == 0) check(1'b0, "R2/R7 unexpected read", int'(mem_addr), 0);
        else begin
          logic [11:0] e;
          e = rd_q.pop_front();
          check(mem_addr == e, "R2/R7/R8/R9 read address", int'(mem_addr), int'(e));
        end
      end
      if (mem_wr && mem_ready) begin
        if (wr_q.size() == 0) check(1'b0, "R5 unexpected write", int'(mem_addr), 0);
        else begin
          wr_item_t e;
          e = wr_q.pop_front();
          check(mem_addr == e.a, "R5 write address", int'(mem_addr), int'(e.a));
          check(mem_wdata == e.d, "R4/R6 write data", int'(mem_wdata), int'(e.d));
        end
      end
      prev_stall <= (mem_rd || mem_wr) && !mem_ready;
      prev_rd    <= mem_rd;
      prev_wr    <= mem_wr;
      prev_addr  <= mem_addr;
      prev_wdata <= mem_wdata;
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // ---------------- driver helpers ----------------
  task automatic poke(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    ld_addr = a; ld_data = d; ld_en = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
    return {op, a};
  endfunction

  task automatic run_to_halt(output int states);
    states = 0;
    rst = 1'b0;
    do begin
      @(posedge clk); states++;
      @(negedge clk);
    end while (!halted && states < 5000);
  endtask

  task automatic load_main;
    for (int i = 0; i < 256; i++) poke(8'(i), 16'hAAAA);
    poke(8'h80, 16'd5);  poke(8'h81, 16'd7);
    poke(8'h82, 16'd12); poke(8'h83, 16'd1);
    poke(0,  ins(4'h1, 12'h080));
    poke(1,  ins(4'h3, 12'h081));
    poke(2,  ins(4'h2, 12'h090));
    poke(3,  ins(4'h4, 12'h082));
    poke(4,  ins(4'h6, 12'h007));
    poke(5,  ins(4'h2, 12'h091));
    poke(6,  ins(4'h7, 12'h000));
    poke(7,  ins(4'h2, 12'h092));
    poke(8,  ins(4'h4, 12'h083));
    poke(9,  ins(4'h6, 12'h005));
    poke(10, ins(4'h2, 12'h093));
    poke(11, ins(4'h3, 12'h083));
    poke(12, ins(4'h5, 12'h00E));
    poke(13, ins(4'h2, 12'h094));
    poke(14, 16'hF000);
    poke(15, ins(4'h7, 12'h000));
  endtask

  task automatic push_main;
    logic [15:0] acc_m;
    expect_read(12'h000); expect_read(12'h080); acc_m = 16'd5;              // R4
    expect_read(12'h001); expect_read(12'h081); acc_m = acc_m + 16'd7;      // R6
    expect_read(12'h002); expect_write(12'h090, acc_m);                     // R5
    expect_read(12'h003); expect_read(12'h082); acc_m = acc_m - 16'd12;     // R6
    expect_read(12'h004);                                                   // R9 taken
    expect_read(12'h007); expect_write(12'h092, acc_m);
    expect_read(12'h008); expect_read(12'h083); acc_m = acc_m - 16'd1;      // R6 wrap
    expect_read(12'h009);                                                   // R9 not taken
    expect_read(12'h00A); expect_write(12'h093, acc_m);
    expect_read(12'h00B); expect_read(12'h083); acc_m = acc_m + 16'd1;
    expect_read(12'h00C);                                                   // R8
    expect_read(12'h00E);                                                   // R3 no-op
    expect_read(12'h00F);                                                   // R10
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int st;
    rst = 1'b1;
    load_main();
    @(negedge clk);
    // R1 reset state
    check(!halted && !mem_rd && !mem_wr, "R1 reset outputs quiet",
          {mem_rd, mem_wr, halted}, 0);
    push_main();
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check(mem_rd && mem_addr == 12'h000, "R1/R2 first fetch at 0", int'(mem_addr), 0);
    st = 1;
    do begin
      @(posedge clk); st++;
      @(negedge clk);
    end while (!halted && st < 5000);
    // R11 zero-wait timing: 13 instructions, 65 states
    check(st == 65, "R11 no-stall state count", st, 65);
    check(halted, "R10 halted raised", halted, 1);
    check(rd_q.size() == 0 && wr_q.size() == 0, "R2/R5 scoreboard drained",
          rd_q.size() + wr_q.size(), 0);
    check(bmem[8'h91] == 16'hAAAA, "R9 skipped store left memory", int'(bmem[8'h91]), 16'hAAAA);
    check(bmem[8'h94] == 16'hAAAA, "R8 skipped store left memory", int'(bmem[8'h94]), 16'hAAAA);
    check(bmem[8'h93] == 16'hFFFF, "R6 subtract wrap stored", int'(bmem[8'h93]), 16'hFFFF);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(halted && !mem_rd && !mem_wr, "R10 stays halted and quiet",
            {mem_rd, mem_wr, halted}, 1);
    end

    // second pass: same program with random wait states
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check(!halted, "R10 reset clears halt", halted, 0);
    ready_rand = 1'b1;
    push_main();
    run_to_halt(st);
    check(halted, "R10 halted after stalled run", halted, 1);
    check(st > 65, "R11 stalls stretch the run", st, 66);
    check(rd_q.size() == 0 && wr_q.size() == 0, "R5/R11 scoreboard drained under stalls",
          rd_q.size() + wr_q.size(), 0);

    // third pass: add overflow, stalls on
    rst = 1'b1;
    poke(8'h84, 16'hFFF0); poke(8'h85, 16'h0020);
    poke(0, ins(4'h1, 12'h084));
    poke(1, ins(4'h3, 12'h085));
    poke(2, ins(4'h2, 12'h095));
    poke(3, ins(4'h7, 12'h000));
    expect_read(12'h000); expect_read(12'h084);
    expect_read(12'h001); expect_read(12'h085);
    expect_read(12'h002); expect_write(12'h095, 16'(16'hFFF0 + 16'h0020)); // R6 carry dropped
    expect_read(12'h003);
    run_to_halt(st);
    check(halted, "R10 halt in third program", halted, 1);
    check(bmem[8'h95] == 16'h0010, "R6 add wrap stored", int'(bmem[8'h95]), 16'h0010);
    check(rd_q.size() == 0 && wr_q.size() == 0, "R4 scoreboard drained",
          rd_q.size() + wr_q.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule